// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Anti-Backlash Hold

This block compares two event streams, a reference and a feedback, and turns their relative timing into pump-up and pump-down commands for a downstream charge pump. It runs on a fast system clock. Both inputs are single-cycle strobes that have already been synchronized and edge-detected upstream. A reference event arms the up side and a feedback event arms the down side. Once both sides are armed, they are released together, but only after a programmable hold of whole clock cycles. Because of this hold, two coincident events still produce a pulse of minimum width on both outputs, which keeps the loop out of the dead zone around phase alignment.

A 2-bit drive code summarises the pump state: drive high, drive low, float, or both sources on (net zero). An event that lands while the hold is running is remembered and re-arms its side when the hold ends, so no event is lost. The strobes are plain control inputs with no back-pressure: an event presented in a cycle is consumed in that cycle.

Top module: `pfd_antibacklash`

## Requirements
- R1: A synchronous active-high `rst` clears `up`, `dn`, any remembered event and the hold counter. On the first clock edge after `rst` is released with no strobe present, `up`=0, `dn`=0 and `drive`=2'b00.
- R2: When neither output is high, a `ref_stb` pulse sets `up` at the clock edge that samples it, and a `fb_stb` pulse sets `dn` at the edge that samples it.
- R3: The `drive` code is 2'b01 when only `up` is high (drive high), 2'b10 when only `dn` is high (drive low), 2'b00 when neither is high (float) and 2'b11 when both are high (balanced).
- R4: Once `up` and `dn` are both high, they stay high together for exactly D cycles and then fall at the same edge. D is `abl_dly` when it is non-zero and 1 when `abl_dly` is 0. `abl_dly` must be held stable while a pulse is in progress.
- R5: Reference and feedback strobes in the same cycle give `up` and `dn` pulses that are both exactly D cycles wide.
- R6: A feedback strobe L cycles after a reference strobe gives an `up` pulse of L+D cycles and a `dn` pulse of D cycles, with `drive` at 2'b01 for L cycles. The mirrored order gives `dn` L+D cycles, `up` D cycles and `drive` at 2'b10 for L cycles.
- R7: A strobe that arrives while both outputs are high, including in the last cycle of the hold, is remembered. At the release edge its output stays or becomes high while the other output falls.
- R8: A repeated `ref_stb` while `up` is already high and `dn` is low has no effect. The `up` pulse still ends D cycles after the feedback strobe.
- R9: With reference strobes much more frequent than feedback strobes, `drive` is 2'b01 for more than half of all cycles and 2'b10 for less than a quarter of them. The converse holds when the feedback strobes are the more frequent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Single-cycle reference event strobe |
| fb_stb | input | 1 | Single-cycle feedback event strobe |
| abl_dly | input | 4 | Anti-backlash hold length in cycles (0 acts as 1) |
| up | output | 1 | Pump-up command |
| dn | output | 1 | Pump-down command |
| drive | output | 2 | Pump state: 00 float, 01 high, 10 low, 11 both |

## Verification
The bench builds the block with the default 4-bit hold width. This allows every hold setting from 0 to 15 to be swept against every lead and lag from -6 to +6 cycles, with the expected pulse widths and drive-code occupancy worked out arithmetically. Directed cases add events during the hold and on its final cycle, repeated reference events, a reset in the middle of a pulse, and long runs at two very unequal event rates in both directions.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    DRV_FLOAT = 2'b00,
    DRV_HIGH  = 2'b01,
    DRV_LOW   = 2'b10,
    DRV_BOTH  = 2'b11
  } drive_e;
endpackage

// File: rtl/pfd_edge_flop.sv
// One side of the detector: armed by a strobe, released by the shared clear,
// with a one-event memory for strobes that land during the hold.
module pfd_edge_flop (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q    <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      q_q    <= pend_q | set_i;
      pend_q <= 1'b0;
    end else if (busy_i) begin
      if (set_i) pend_q <= 1'b1;
    end else if (set_i) begin
      q_q <= 1'b1;
    end
  end

  assign q_o = q_q;

  // R1: reset empties the flop and its memory
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!q_q && !pend_q));
  // R2: a flop only rises because of a strobe or a remembered one
  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(q_q) |-> ($past(set_i) || $past(pend_q)));
  // R7: a strobe during the hold is remembered
  a_r7_hold_strobe_kept: assert property (@(posedge clk) disable iff (rst)
    (busy_i && set_i && !clr_i) |=> pend_q);
endmodule

// File: rtl/pfd_abl_timer.sv
// Counts the cycles both sides are armed and issues the shared clear.
module pfd_abl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             both_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;

  assign eff   = (delay_i == '0) ? ONE : delay_i;
  assign clr_o = both_i && (cnt_q == eff - ONE);

  always_ff @(posedge clk) begin
    if (rst || !both_i || clr_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + ONE;
  end

  // R4: the hold count never passes the programmed length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    both_i |-> (cnt_q < eff));
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_stb,
  input  logic             fb_stb,
  input  logic [DLY_W-1:0] abl_dly,
  output logic             up,
  output logic             dn,
  output logic [1:0]       drive
);
  import pfd_pkg::*;

  localparam int SIDES = 2;

  logic [SIDES-1:0] set_v;
  logic [SIDES-1:0] q_v;
  logic             both;
  logic             clr;
  drive_e           drv;

  assign set_v = {fb_stb, ref_stb};
  assign both  = &q_v;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pfd_edge_flop u_flop (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_v[s]),
      .busy_i (both),
      .clr_i  (clr),
      .q_o    (q_v[s])
    );
  end

  pfd_abl_timer #(.CNT_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .both_i  (both),
    .delay_i (abl_dly),
    .clr_o   (clr)
  );

  always_comb begin
    case (q_v)
      2'b01:   drv = DRV_HIGH;
      2'b10:   drv = DRV_LOW;
      2'b11:   drv = DRV_BOTH;
      default: drv = DRV_FLOAT;
    endcase
  end

  assign up    = q_v[0];
  assign dn    = q_v[1];
  assign drive = drv;

  // R4: the shared clear only ever fires while both sides are armed
  a_r4_clear_only_when_both: assert property (@(posedge clk) disable iff (rst)
    clr |-> (up && dn));
endmodule

// File: tb/pfd_antibacklash_tb.sv
module pfd_antibacklash_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_stb = 1'b0;
  logic       fb_stb = 1'b0;
  logic [3:0] abl_dly = 4'd1;
  logic       up, dn;
  logic [1:0] drive;

  int checks = 0;
  int errors = 0;
  int n_up, n_dn, n_hi, n_lo, n_bo, n_fl;

  always #5 clk = ~clk;

  pfd_antibacklash u_dut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .abl_dly(abl_dly), .up(up), .dn(dn), .drive(drive)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_up = 0; n_dn = 0; n_hi = 0; n_lo = 0; n_bo = 0; n_fl = 0;
  endtask

  task automatic sample();
    if (up) n_up++;
    if (dn) n_dn++;
    case (drive)
      2'b01: n_hi++;
      2'b10: n_lo++;
      2'b11: n_bo++;
      default: n_fl++;
    endcase
  endtask

  // one negedge: count the present state, then present the next strobes
  task automatic step(logic r, logic f);
    @(negedge clk);
    sample();
    ref_stb = r;
    fb_stb  = f;
  endtask

  task automatic run_pair(int d, int lead);
    int de = (d == 0) ? 1 : d;
    int al = (lead < 0) ? -lead : lead;
    abl_dly = 4'(d);
    clr_counts();
    for (int c = 0; c < 40; c++)
      step((lead >= 0) ? (c == 0) : (c == al), (lead >= 0) ? (c == lead) : (c == 0));
    step(1'b0, 1'b0);
    if (lead == 0) begin
      check("R5 aligned up width", n_up, de);
      check("R5 aligned dn width", n_dn, de);
    end else if (lead > 0) begin
      check("R6 lead up width", n_up, al + de);
      check("R6 lead dn width", n_dn, de);
    end else begin
      check("R6 lag up width", n_up, de);
      check("R6 lag dn width", n_dn, al + de);
    end
    check("R4 both-high cycles", n_bo, de);
    check("R3 drive high cycles", n_hi, (lead > 0) ? al : 0);
    check("R3 drive low cycles", n_lo, (lead < 0) ? al : 0);
  endtask

  task automatic run_rates(int pr, int pf, bit ref_fast);
    abl_dly = 4'd2;
    clr_counts();
    for (int c = 0; c < 2200; c++) step((c % pr) == 0, (c % pf) == 0);
    step(1'b0, 1'b0);
    if (ref_fast) begin
      check("R9 fast ref high majority", int'(n_hi * 2 > 2201), 1);
      check("R9 fast ref low minority", int'(n_lo * 4 < 2201), 1);
    end else begin
      check("R9 fast fb low majority", int'(n_lo * 2 > 2201), 1);
      check("R9 fast fb high minority", int'(n_hi * 4 < 2201), 1);
    end
    repeat (60) step(1'b1, 1'b1);
    repeat (40) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset up", int'(up), 0);
    check("R1 reset dn", int'(dn), 0);
    check("R1 reset drive float", int'(drive), 0);

    // R2: a single reference strobe arms up at the sampling edge
    abl_dly = 4'd3;
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    check("R2 ref sets up", int'(up), 1);
    check("R2 dn stays low", int'(dn), 0);
    fb_stb = 1'b1;
    @(negedge clk);
    fb_stb = 1'b0;
    check("R2 fb sets dn", int'(dn), 1);
    repeat (5) @(negedge clk);

    for (int d = 0; d < 16; d++)
      for (int l = -6; l <= 6; l++) run_pair(d, l);

    // R7: ref strobe in the middle of the hold re-arms up at release
    abl_dly = 4'd4;
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (3) step(1'b0, 1'b0);
    check("R7 up re-armed after hold", int'(up), 1);
    check("R7 dn released", int'(dn), 0);
    check("R7 drive high", int'(drive), 1);
    step(1'b0, 1'b1);
    repeat (8) step(1'b0, 1'b0);
    check("R7 settles to float", int'(drive), 0);

    // R7: feedback strobe on the last hold cycle
    abl_dly = 4'd3;
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    check("R7 last-cycle dn kept", int'(dn), 1);
    check("R7 last-cycle up released", int'(up), 0);
    step(1'b1, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    check("R7 last-cycle settles", int'(drive), 0);

    // R8: repeated reference strobes do not extend or restart up
    abl_dly = 4'd2;
    clr_counts();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    repeat (10) step(1'b0, 1'b0);
    check("R8 up width ignores repeats", n_up, 7);
    check("R8 dn width", n_dn, 2);

    // R1: reset in the middle of a hold with a remembered event
    abl_dly = 4'd8;
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    @(negedge clk);
    ref_stb = 1'b0; fb_stb = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid-pulse reset up", int'(up), 0);
    check("R1 mid-pulse reset dn", int'(dn), 0);
    repeat (12) @(negedge clk);
    check("R1 no remembered event after reset", int'(drive), 0);

    run_rates(3, 11, 1'b1);
    run_rates(11, 3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule